// File: doc/BRIEF.md
# Blanking-Interval Caption Line Selector

This block decides which video lines in the vertical blanking interval a closed-caption data slicer should act on. It receives the separated vertical and horizontal sync pulses, which are asynchronous to the system clock. It counts horizontal pulses from the start of each field and raises a one-cycle slice strobe on two lines: the fixed caption line, whose count is set by a parameter, and one line that software picks. Each sliced line carries a clock run-in, then a start bit, then 16 data bits. The slicer downstream handles those and is not part of this block.

The block also tracks field parity. It raises a separate reference strobe that tells the slicer which sliced line should set its slice level from the clock run-in. The field that may produce this strobe comes from a field-select input. The line or lines within that field come from the top two bits of an 8-bit position setting. The low five bits of the same setting hold the programmable line count.

Top module: `vbi_caption_line_sel`

## Requirements
- R1: A falling edge on `vsep_i` clears the line count, so the next horizontal pulse is counted as line 0.
- R2: Each rising edge on `hsep_i` is one line. The pulse that is checked against count N is the (N+1)th after the vertical falling edge, and the count then advances by one.
- R3: A slice strobe is raised for the pulse whose count equals the parameter `CAPTION_LINE` (default 21).
- R4: A slice strobe is raised for the pulse whose count equals `cappos_i[4:0]`, for any value from 0 to 31. Bit 5 of `cappos_i` has no effect.
- R5: When `cappos_i[4:0]` equals `CAPTION_LINE`, that line gives exactly one strobe. No field ever gets more than two slice strobes.
- R6: The count saturates after 32 pulses. Pulses after the 32nd produce no slice strobe until the next vertical falling edge.
- R7: `field_o` is 0 after reset and toggles on every falling edge of `vsep_i`.
- R8: `cappos_i[7:6]` selects the reference line: 00 gives the fixed line, 01 the programmable line, 10 both lines, and 11 no reference strobe.
- R9: `ref_o` is raised only together with `slice_o`, and only while `field_o` equals `fsel_i`.
- R10: If a vertical falling edge and a horizontal rising edge are detected in the same cycle, the count is cleared and that horizontal pulse is not counted or sliced.
- R11: Each strobe is high for exactly one clock cycle. It appears three clock edges after the input edge that causes it, of which two edges are spent in the synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vsep_i | input | 1 | Separated vertical sync, asynchronous |
| hsep_i | input | 1 | Separated horizontal sync, asynchronous |
| cappos_i | input | 8 | [4:0] programmable line count, [5] unused, [7:6] reference line mode |
| fsel_i | input | 1 | Field whose lines may produce the reference strobe |
| slice_o | output | 1 | One-cycle strobe: slice this line |
| ref_o | output | 1 | One-cycle strobe: set the slice level from this line |
| field_o | output | 1 | Field parity flag |

## Verification
The assertions check on every cycle that the count clears and advances as it should, stays within its limit and never wraps. They also check that the field flag moves only on a vertical edge, that strobes follow a horizontal edge, and that a reference strobe never appears without a slice strobe, in the wrong field or with mode 11. Only the bench scenarios can show that the right lines are picked. They compare the full per-line strobe pattern of whole fields against a model for different programmable values, modes and field selects. They also show the coincident-edge case and the result of a reset in the middle of a field.

// File: rtl/vbi_sel_pkg.sv
// Package: shared types and field positions for the caption line selector.
// Assumes: the position setting is 8 bits wide, with the line count in the
// low bits and the reference mode in the top two bits.
package vbi_sel_pkg;

    // Which line(s) of the selected field produce the reference strobe.
    typedef enum logic [1:0] {
        REF_FIXED = 2'b00,
        REF_PROG  = 2'b01,
        REF_BOTH  = 2'b10,
        REF_OFF   = 2'b11
    } ref_mode_e;

    localparam int POS_W    = 8;
    localparam int MODE_LSB = 6;

endpackage

// File: rtl/vbi_sync_edge.sv
// Module: brings one asynchronous pulse into the clock domain and reports
// its rising and falling edges as one-cycle pulses.
// Assumes: the input stays at each level for at least two clock cycles.
module vbi_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o,
    output logic fall_o
);
    // q[STAGES] holds the value from the previous cycle, for edge detection.
    logic [STAGES:0] q;

    // Purpose: shift the input through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= {q[STAGES-1:0], async_i};
    end

    assign rise_o = q[STAGES-1] & ~q[STAGES];
    assign fall_o = ~q[STAGES-1] & q[STAGES];

    // R11: an edge pulse can never last two cycles.
    assert_edge_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/vbi_line_counter.sv
// Module: counts horizontal pulses within a field and keeps the field
// parity flag.
// Assumes: edge inputs are single-cycle pulses. The count saturates at
// 2**LINE_W, which means the window of selectable lines is over.
module vbi_line_counter #(
    parameter int LINE_W = 5,
    localparam int CNT_W = LINE_W + 1,
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(1) << LINE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vfall_i,
    input  logic             hrise_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             field_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             field_q;

    // Purpose: clear on a vertical edge (this wins), otherwise advance on a
    // horizontal edge until the limit is reached.
    always_ff @(posedge clk) begin
        if (!rst_n)                          cnt_q <= '0;
        else if (vfall_i)                    cnt_q <= '0;
        else if (hrise_i && cnt_q != LIMIT)  cnt_q <= cnt_q + CNT_W'(1);
    end

    // Purpose: toggle the field parity on each vertical edge.
    always_ff @(posedge clk) begin
        if (!rst_n)       field_q <= 1'b0;
        else if (vfall_i) field_q <= ~field_q;
    end

    assign cnt_o   = cnt_q;
    assign field_o = field_q;

    assert_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        vfall_i |=> cnt_q == '0);
    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hrise_i && !vfall_i && cnt_q != LIMIT) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIMIT);
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!hrise_i && !vfall_i) |=> $stable(cnt_q));
    assert_field_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vfall_i |=> field_q != $past(field_q));
    assert_field_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !vfall_i |=> $stable(field_q));
endmodule

// File: rtl/vbi_line_match.sv
// Module: compares the count of each horizontal pulse with the fixed and
// programmable lines, and produces the registered slice and reference
// strobes.
// Assumes: the count presented is the value before this pulse is counted.
module vbi_line_match
    import vbi_sel_pkg::*;
#(
    parameter int LINE_W = 5,
    parameter int CAPTION_LINE = 21,
    localparam int CNT_W = LINE_W + 1,
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(1) << LINE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vfall_i,
    input  logic              hrise_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [LINE_W-1:0] prog_i,
    input  ref_mode_e         mode_i,
    input  logic              fsel_i,
    input  logic              field_i,
    output logic              slice_o,
    output logic              ref_o
);
    logic live, fixed_hit, prog_hit, ref_sel;
    logic slice_q, ref_q;

    // Purpose: find which line matches on this pulse.
    always_comb begin
        live      = hrise_i && !vfall_i && (cnt_i < LIMIT);
        fixed_hit = live && (cnt_i == CNT_W'(CAPTION_LINE));
        prog_hit  = live && (cnt_i == {1'b0, prog_i});
    end

    // Purpose: apply the reference mode to the matches.
    always_comb begin
        unique case (mode_i)
            REF_FIXED: ref_sel = fixed_hit;
            REF_PROG:  ref_sel = prog_hit;
            REF_BOTH:  ref_sel = fixed_hit | prog_hit;
            default:   ref_sel = 1'b0;
        endcase
    end

    // Purpose: register both strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slice_q <= 1'b0;
            ref_q   <= 1'b0;
        end else begin
            slice_q <= fixed_hit | prog_hit;
            ref_q   <= ref_sel && (field_i == fsel_i);
        end
    end

    assign slice_o = slice_q;
    assign ref_o   = ref_q;

    assert_slice_after_hs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        slice_q |-> $past(hrise_i) && !$past(vfall_i));
    assert_ref_in_slice_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ref_q |-> slice_q);
    assert_ref_field_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ref_q |-> $past(field_i) == $past(fsel_i));
    assert_ref_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mode_i) == REF_OFF |-> !ref_q);
    assert_no_slice_past_R6: assert property (@(posedge clk) disable iff (!rst_n)
        slice_q |-> $past(cnt_i) < LIMIT);
    assert_one_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        slice_q |=> !slice_q);
endmodule

// File: rtl/vbi_caption_line_sel.sv
// Module: top of the caption line selector. Synchronises both sync pulses,
// counts lines and issues the slice and reference strobes.
// Assumes: sync pulses last at least two clock cycles at each level.
// Position setting: [4:0] programmable line, [7:6] reference mode.
module vbi_caption_line_sel
    import vbi_sel_pkg::*;
#(
    parameter int LINE_W = 5,
    parameter int CAPTION_LINE = 21,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vsep_i,
    input  logic             hsep_i,
    input  logic [POS_W-1:0] cappos_i,
    input  logic             fsel_i,
    output logic             slice_o,
    output logic             ref_o,
    output logic             field_o
);
    localparam int CNT_W = LINE_W + 1;
    localparam int NSYNC = 2;

    logic [NSYNC-1:0] async_in, rise, fall;
    logic [CNT_W-1:0] cnt;
    logic             field;
    ref_mode_e        mode;

    assign async_in = {hsep_i, vsep_i};

    // One synchroniser per sync input: index 0 vertical, index 1 horizontal.
    for (genvar g = 0; g < NSYNC; g++) begin : g_sync
        vbi_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
            .clk(clk), .rst_n(rst_n), .async_i(async_in[g]),
            .rise_o(rise[g]), .fall_o(fall[g])
        );
    end

    assign mode = ref_mode_e'(cappos_i[MODE_LSB +: 2]);

    vbi_line_counter #(.LINE_W(LINE_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .vfall_i(fall[0]), .hrise_i(rise[1]),
        .cnt_o(cnt), .field_o(field)
    );

    vbi_line_match #(.LINE_W(LINE_W), .CAPTION_LINE(CAPTION_LINE)) u_match (
        .clk(clk), .rst_n(rst_n), .vfall_i(fall[0]), .hrise_i(rise[1]),
        .cnt_i(cnt), .prog_i(cappos_i[LINE_W-1:0]), .mode_i(mode),
        .fsel_i(fsel_i), .field_i(field), .slice_o(slice_o), .ref_o(ref_o)
    );

    assign field_o = field;

    assert_reset_quiet_R7: assert property (@(posedge clk)
        !rst_n |=> !slice_o && !ref_o && !field_o);
endmodule

// File: tb/tb_vbi_caption_line_sel.sv
module tb_vbi_caption_line_sel;
    localparam int CLK_PERIOD = 10;
    localparam int NLINES = 34;
    localparam int CAP = 21;

    logic clk = 0, rst_n = 0, vsep = 0, hsep = 0, fsel = 0;
    logic [7:0] cappos = 0;
    logic slice, refs, field;
    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vbi_caption_line_sel dut (
        .clk(clk), .rst_n(rst_n), .vsep_i(vsep), .hsep_i(hsep),
        .cappos_i(cappos), .fsel_i(fsel), .slice_o(slice), .ref_o(refs),
        .field_o(field)
    );

    // {cappos, fsel, expected slices per field, expected references per field}
    localparam logic [16:0] VEC [0:7] = '{
        {8'h05, 1'b1, 4'd2, 4'd1},
        {8'h05, 1'b1, 4'd2, 4'd0},
        {8'h69, 1'b1, 4'd2, 4'd1},
        {8'h89, 1'b0, 4'd2, 4'd2},
        {8'h95, 1'b1, 4'd1, 4'd1},
        {8'hC0, 1'b0, 4'd2, 4'd0},
        {8'h5F, 1'b1, 4'd2, 4'd1},
        {8'h80, 1'b0, 4'd2, 4'd2}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One horizontal pulse; counts the strobe cycles seen in its window.
    task automatic hs_pulse(output int ns, output int nr);
        ns = 0; nr = 0;
        @(negedge clk); hsep = 1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (i == 1) hsep = 0;
            ns += int'(slice); nr += int'(refs);
        end
    endtask

    task automatic vs_fall();
        @(negedge clk); vsep = 1;
        repeat (4) @(negedge clk);
        vsep = 0;
        repeat (6) @(negedge clk);
    endtask

    function automatic bit exp_slice(int k, logic [7:0] cp);
        return k < 32 && (k == CAP || k == int'(cp[4:0]));
    endfunction

    function automatic bit exp_ref(int k, logic [7:0] cp, logic fs, logic fld);
        bit fx = k < 32 && k == CAP;
        bit pg = k < 32 && k == int'(cp[4:0]);
        bit s;
        case (cp[7:6])
            2'b00: s = fx;
            2'b01: s = pg;
            2'b10: s = fx | pg;
            default: s = 0;
        endcase
        return s && (fs == fld);
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int ns, nr, ts, tr, bad;
        logic mfield;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R7: reset state
        chk("R7 reset field", field, 0);
        chk("R11 reset strobes", slice | refs, 0);

        mfield = 0;
        for (int v = 0; v < 8; v++) begin
            cappos = VEC[v][16:9];
            fsel   = VEC[v][8];
            vs_fall();
            mfield = ~mfield;
            chk("R7 field toggle", field, mfield);
            ts = 0; tr = 0; bad = 0;
            for (int k = 0; k < NLINES; k++) begin
                hs_pulse(ns, nr);
                ts += ns; tr += nr;
                if (ns != int'(exp_slice(k, cappos))) bad++;
                if (nr != int'(exp_ref(k, cappos, fsel, mfield))) bad++;
            end
            // R3 R4 R5 R6 R11: per-line strobe pattern and totals
            chk("R2 R3 R4 R6 R11 line pattern mismatches", bad, 0);
            chk("R5 slices per field", ts, int'(VEC[v][7:4]));
            chk("R8 R9 references per field", tr, int'(VEC[v][3:0]));
        end

        // R10: coincident vertical and horizontal edges
        cappos = 8'h00; fsel = field;
        @(negedge clk); vsep = 1;
        repeat (4) @(negedge clk);
        vsep = 0; hsep = 1;
        ns = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (i == 1) hsep = 0;
            ns += int'(slice);
        end
        chk("R10 coincident pulse not sliced", ns, 0);
        hs_pulse(ns, nr);
        chk("R10 R1 next pulse is line 0", ns, 1);
        hs_pulse(ns, nr);
        chk("R2 line 1 not sliced", ns, 0);

        // R7: reset in mid-field clears the flag
        mfield = field;
        chk("R7 field before reset", field, 1);
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        chk("R7 field after reset", field, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule